// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block produces the timing for a telephony PCM highway from a single fixed reference oscillator of 32.768 MHz. A 3-bit rate code picks one of five bit clock rates between 512 kHz and 8.192 MHz. A frame sync recurs every 4096 reference cycles, which gives 8 kHz, whatever the rate. A separate enable gates the frame sync. The bit clock is a division of one free-running frame counter, so bit clock and frame sync never drift apart. A new rate code is only taken up at a frame boundary.

For bench work with external test gear, two independent selects replace the internal bit clock and the internal frame sync with externally supplied ones. The data lines toward and from the codec are routed to the tester pins. A loopback mode instead returns the codec's transmit data to its receive input, retimed by one reference clock. All pins are plain control and data wires: no data stream with flow control crosses this boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pcm_timing_gen`

## Requirements
- R1: While `rst_n` is low, `bit_clk_o` and `frame_sync_o` are 0 (internal sources selected).
- R2: Rate codes 000, 001, 010 and 011 give a bit clock period of 4, 8, 16 and 32 reference cycles. The clock is high for the first half of each period and low for the second.
- R3: Any rate code with bit 2 set gives a period of 64 reference cycles, whatever bits 1:0 hold.
- R4: A frame is 4096 reference cycles. The frame sync is high for exactly one bit clock period per frame, and it rises together with the bit clock's first rising edge of the frame.
- R5: A change of the rate code inside a frame has no effect until the next frame boundary. The new rate then starts with a full high half-period.
- R6: With `fs_enable_i` low, the internal frame sync stays low and the frame counter keeps running, so the next enabled pulse keeps the frame phase.
- R7: `bclk_src_tst_i`=1 routes `tst_bclk_i` to `bit_clk_o`. `fsync_src_tst_i`=1 routes `tst_fsync_i` to `frame_sync_o`. Each select acts alone.
- R8: With `loopback_i`=1, `line_rx_o` shows `line_tx_i` as sampled at the last reference edge. With `loopback_i`=0, it follows `tst_rx_i`.
- R9: `tst_tx_o` always follows `line_tx_i`.
- R10: The first reference edge after reset release is a frame boundary and samples the rate code. `bit_clk_o` and `frame_sync_o` rise on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code_i | input | 3 | Bit clock rate code |
| fs_enable_i | input | 1 | Internal frame sync enable |
| bclk_src_tst_i | input | 1 | 1 selects the external bit clock |
| fsync_src_tst_i | input | 1 | 1 selects the external frame sync |
| loopback_i | input | 1 | 1 returns codec transmit data to its receive line |
| tst_bclk_i | input | 1 | External bit clock |
| tst_fsync_i | input | 1 | External frame sync |
| tst_rx_i | input | 1 | Receive data from the tester |
| line_tx_i | input | 1 | Transmit data from the codec |
| bit_clk_o | output | 1 | Bit clock to the codec |
| frame_sync_o | output | 1 | Frame sync to the codec |
| line_rx_o | output | 1 | Receive data to the codec |
| tst_tx_o | output | 1 | Transmit data to the tester |

## Verification
The bench walks through every rate code, including three codes of the 1xx group. It compares each reference cycle against an arithmetic model, which separates wrong divide ratios, wrong duty phase and an aliased low-bit decode. The rate code is changed in the middle of frames, which shows whether the change waits for the boundary. The frame sync enable is dropped and raised across a frame boundary, which tells a frame counter that stops apart from one that keeps running. Random values on the tester and codec data pins, with each select and loopback set on its own, show whether the routes are independent and whether the loopback is retimed.

// File: rtl/pcm_timing_pkg.sv
package pcm_timing_pkg;
  localparam int RATE_W = 3;

  // Rate code to log2 of the reference divide ratio.
  function automatic int code_to_shift(input logic [RATE_W-1:0] code,
                                       input int min_shift,
                                       input int slow_shift);
    if (code[RATE_W-1]) return slow_shift;
    return min_shift + int'(code[RATE_W-2:0]);
  endfunction
endpackage

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int FRAME_LOG2 = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [FRAME_LOG2-1:0] cnt_o,
  output logic                  wrap_o
);
  // Reset value is the last count, so the first edge is a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '1;
    else        cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = &cnt_o;
endmodule

// File: rtl/pcm_rate_hold.sv
module pcm_rate_hold
  import pcm_timing_pkg::*;
#(
  parameter int SHIFT_W    = 4,
  parameter int MIN_SHIFT  = 2,
  parameter int SLOW_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrap_i,
  input  logic [RATE_W-1:0]  rate_code_i,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [SHIFT_W-1:0] shift_next;

  always_comb shift_next = SHIFT_W'(code_to_shift(rate_code_i, MIN_SHIFT, SLOW_SHIFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shift_o <= SHIFT_W'(MIN_SHIFT);
    else if (wrap_i) shift_o <= shift_next;
  end
endmodule

// File: rtl/pcm_edge_shaper.sv
module pcm_edge_shaper #(
  parameter int FRAME_LOG2 = 12,
  parameter int SHIFT_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAME_LOG2-1:0] cnt_i,
  input  logic [SHIFT_W-1:0]    shift_i,
  input  logic                  fs_en_i,
  output logic                  bclk_o,
  output logic                  fs_o
);
  localparam logic [SHIFT_W-1:0] ONE = SHIFT_W'(1);

  logic [FRAME_LOG2-1:0] half_idx;
  logic [FRAME_LOG2-1:0] period_idx;
  logic                  bclk_d;
  logic                  fs_d;

  always_comb begin
    half_idx   = cnt_i >> (shift_i - ONE);
    period_idx = cnt_i >> shift_i;
    bclk_d     = ~half_idx[0];
    fs_d       = fs_en_i && (period_idx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_o <= 1'b0;
      fs_o   <= 1'b0;
    end else begin
      bclk_o <= bclk_d;
      fs_o   <= fs_d;
    end
  end
endmodule

// File: rtl/pcm_route.sv
module pcm_route (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_int_i,
  input  logic fs_int_i,
  input  logic bclk_src_tst_i,
  input  logic fsync_src_tst_i,
  input  logic loopback_i,
  input  logic tst_bclk_i,
  input  logic tst_fsync_i,
  input  logic tst_rx_i,
  input  logic line_tx_i,
  output logic bit_clk_o,
  output logic frame_sync_o,
  output logic line_rx_o,
  output logic tst_tx_o
);
  logic tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= line_tx_i;
  end

  always_comb begin
    bit_clk_o    = bclk_src_tst_i  ? tst_bclk_i  : bclk_int_i;
    frame_sync_o = fsync_src_tst_i ? tst_fsync_i : fs_int_i;
    line_rx_o    = loopback_i ? tx_q : tst_rx_i;
    tst_tx_o     = line_tx_i;
  end
endmodule

// File: rtl/pcm_timing_gen.sv
module pcm_timing_gen
  import pcm_timing_pkg::*;
#(
  parameter int FRAME_LOG2 = 12,
  parameter int MIN_SHIFT  = 2,
  parameter int SLOW_SHIFT = 6
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              fs_enable_i,
  input  logic              bclk_src_tst_i,
  input  logic              fsync_src_tst_i,
  input  logic              loopback_i,
  input  logic              tst_bclk_i,
  input  logic              tst_fsync_i,
  input  logic              tst_rx_i,
  input  logic              line_tx_i,
  output logic              bit_clk_o,
  output logic              frame_sync_o,
  output logic              line_rx_o,
  output logic              tst_tx_o
);
  localparam int SHIFT_W = $clog2(FRAME_LOG2 + 1);

  logic [FRAME_LOG2-1:0] frame_cnt;
  logic                  frame_wrap;
  logic [SHIFT_W-1:0]    shift_act;
  logic                  bclk_int;
  logic                  fs_int;

  pcm_frame_ctr #(.FRAME_LOG2(FRAME_LOG2)) u_ctr (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .cnt_o  (frame_cnt),
    .wrap_o (frame_wrap)
  );

  pcm_rate_hold #(
    .SHIFT_W   (SHIFT_W),
    .MIN_SHIFT (MIN_SHIFT),
    .SLOW_SHIFT(SLOW_SHIFT)
  ) u_rate (
    .clk         (clk_ref),
    .rst_n       (rst_n),
    .wrap_i      (frame_wrap),
    .rate_code_i (rate_code_i),
    .shift_o     (shift_act)
  );

  pcm_edge_shaper #(
    .FRAME_LOG2(FRAME_LOG2),
    .SHIFT_W   (SHIFT_W)
  ) u_shape (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .cnt_i   (frame_cnt),
    .shift_i (shift_act),
    .fs_en_i (fs_enable_i),
    .bclk_o  (bclk_int),
    .fs_o    (fs_int)
  );

  pcm_route u_route (
    .clk             (clk_ref),
    .rst_n           (rst_n),
    .bclk_int_i      (bclk_int),
    .fs_int_i        (fs_int),
    .bclk_src_tst_i  (bclk_src_tst_i),
    .fsync_src_tst_i (fsync_src_tst_i),
    .loopback_i      (loopback_i),
    .tst_bclk_i      (tst_bclk_i),
    .tst_fsync_i     (tst_fsync_i),
    .tst_rx_i        (tst_rx_i),
    .line_tx_i       (line_tx_i),
    .bit_clk_o       (bit_clk_o),
    .frame_sync_o    (frame_sync_o),
    .line_rx_o       (line_rx_o),
    .tst_tx_o        (tst_tx_o)
  );
endmodule

// File: rtl/pcm_timing_gen_chk.sv
module pcm_timing_gen_chk #(
  parameter int SHIFT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrap,
  input logic [SHIFT_W-1:0] shift_act,
  input logic               bclk_int,
  input logic               fs_int,
  input logic               fs_enable_i,
  input logic               loopback_i,
  input logic               line_tx_i,
  input logic               line_rx_o
);
  // R1: internal timing held low during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!bclk_int && !fs_int)
        else $error("R1 internal timing not low in reset");
    end
  end

  // R4: frame sync starts with a bit clock rising edge
  a_r4_fs_on_bclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_int) |-> $rose(bclk_int));

  // R5: rate only moves at a frame boundary
  a_r5_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(shift_act));

  // R6: disabled frame sync stays low
  a_r6_fs_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_enable_i |=> !fs_int);

  // R8: loopback returns last sampled transmit bit
  a_r8_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_i |=> (!loopback_i || line_rx_o == $past(line_tx_i)));
endmodule

bind pcm_timing_gen pcm_timing_gen_chk #(.SHIFT_W(SHIFT_W)) u_chk (
  .clk         (clk_ref),
  .rst_n       (rst_n),
  .wrap        (frame_wrap),
  .shift_act   (shift_act),
  .bclk_int    (bclk_int),
  .fs_int      (fs_int),
  .fs_enable_i (fs_enable_i),
  .loopback_i  (loopback_i),
  .line_tx_i   (line_tx_i),
  .line_rx_o   (line_rx_o)
);

// File: tb/pcm_timing_gen_test.sv
module pcm_timing_gen_test;
  localparam int PERIOD = 10;
  localparam int FRAME  = 4096;

  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_code_i = 3'd0;
  logic       fs_enable_i = 1'b1;
  logic       bclk_src_tst_i = 1'b0;
  logic       fsync_src_tst_i = 1'b0;
  logic       loopback_i = 1'b0;
  logic       tst_bclk_i = 1'b0;
  logic       tst_fsync_i = 1'b0;
  logic       tst_rx_i = 1'b0;
  logic       line_tx_i = 1'b0;
  logic       bit_clk_o, frame_sync_o, line_rx_o, tst_tx_o;

  int total = 0;
  int bad = 0;
  int n = 0;
  int cur_div = 4;
  bit done = 1'b0;

  always #(PERIOD/2) clk_ref = ~clk_ref;

  pcm_timing_gen uut (
    .clk_ref, .rst_n, .rate_code_i, .fs_enable_i, .bclk_src_tst_i,
    .fsync_src_tst_i, .loopback_i, .tst_bclk_i, .tst_fsync_i, .tst_rx_i,
    .line_tx_i, .bit_clk_o, .frame_sync_o, .line_rx_o, .tst_tx_o
  );

  function automatic int div_of(input logic [2:0] c);
    return c[2] ? 64 : (4 << c[1:0]);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  task automatic step();
    logic exp_b, exp_f;
    string tb_tag, tf_tag;
    @(posedge clk_ref);
    n++;
    @(negedge clk_ref);
    if (n == 1) begin
      exp_b = 1'b0; exp_f = 1'b0; tb_tag = "R10"; tf_tag = "R10";
    end else begin
      int fi = (n - 2) % FRAME;
      exp_b = (fi % cur_div) < (cur_div / 2);
      exp_f = fs_enable_i && (fi < cur_div);
      if (div_of(rate_code_i) != cur_div) tb_tag = "R5";
      else if (cur_div == 64)             tb_tag = "R3";
      else                                tb_tag = "R2";
      tf_tag = fs_enable_i ? "R4" : "R6";
    end
    if (bclk_src_tst_i) chk("R7", bit_clk_o, tst_bclk_i);
    else                chk(tb_tag, bit_clk_o, exp_b);
    if (fsync_src_tst_i) chk("R7", frame_sync_o, tst_fsync_i);
    else                 chk(tf_tag, frame_sync_o, exp_f);
    if (loopback_i) chk("R8", line_rx_o, line_tx_i);
    else            chk("R8", line_rx_o, tst_rx_i);
    chk("R9", tst_tx_o, line_tx_i);
    if ((n - 1) % FRAME == 0) cur_div = div_of(rate_code_i);
    line_tx_i   = 1'($urandom);
    tst_rx_i    = 1'($urandom);
    tst_bclk_i  = 1'($urandom);
    tst_fsync_i = 1'($urandom);
  endtask

  task automatic run(input int k);
    for (int j = 0; j < k; j++) step();
  endtask

  initial begin
    // R1: outputs low in reset while inputs move
    for (int j = 0; j < 6; j++) begin
      @(negedge clk_ref);
      rate_code_i = 3'(j);
      chk("R1", bit_clk_o, 1'b0);
      chk("R1", frame_sync_o, 1'b0);
    end
    rate_code_i = 3'd0;
    rst_n = 1'b1;
    n = 0;
    run(3000);
    rate_code_i = 3'd1;          // mid-frame change, R5
    run(4096);
    rate_code_i = 3'd2;
    run(4096);
    fs_enable_i = 1'b0;          // R6 gating across a boundary
    run(2000);
    rate_code_i = 3'd3;
    run(3000);
    fs_enable_i = 1'b1;
    run(4096);
    rate_code_i = 3'd4;          // R3 variants of 1xx
    run(4096);
    rate_code_i = 3'd7;
    run(4096);
    rate_code_i = 3'd5;
    run(4096);
    bclk_src_tst_i = 1'b1;       // R7 bit clock only
    run(300);
    bclk_src_tst_i = 1'b0;
    fsync_src_tst_i = 1'b1;      // R7 frame sync only
    run(300);
    fsync_src_tst_i = 1'b0;
    loopback_i = 1'b1;           // R8
    run(500);
    loopback_i = 1'b0;
    rate_code_i = 3'd0;
    run(4200);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at edge %0d: actual=running expected=finished", n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule